// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Slave

This block is a two-wire serial slave that stands in for a 256-byte identification EEPROM on a memory module. It watches a clock line (SCL) and a data line (SDA) and pulls SDA low through an open-drain output when it acknowledges or sends a zero. Three strap inputs set the low bits of its bus address, so up to eight of these devices can share one bus. Both lines are oversampled by a faster system clock through a two-flop synchroniser. Start and stop conditions are recognised only when SDA moves while SCL is high.

A master stores a byte by addressing the slave for write, sending a word pointer and then one data byte. The stop condition that closes such a write begins a timed busy period, counted in system clocks. While it runs, the slave does not answer its address. A master reads by setting the pointer in a write, issuing a repeated start and addressing the slave for read. The slave returns the byte at the pointer and moves the pointer on by one after each byte it sends. The master acknowledges each byte it wants to follow and leaves the last one unacknowledged. The lower 128 bytes come out of reset holding identification data and the upper 128 bytes come out erased, and every location can be written.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset, SDA is released. The byte at location a (0..127) reads as (37*a + 11) mod 256, and every byte at 128..255 reads as 0xFF.
- R2: The slave acknowledges, by holding SDA low through the ninth clock, only an address byte whose bits 7:4 are 1010 and bits 3:1 equal strap_i. Bit 0 is 1 for read and 0 for write. Any other address byte is not acknowledged.
- R3: In a write, the first data byte is acknowledged and loads the word pointer. The second data byte is acknowledged and stored at that pointer, and the pointer then advances by one. This holds in both halves of the storage.
- R4: A write carrying only the pointer, followed by a repeated start and a read address, returns the byte at that pointer.
- R5: Each byte sent advances the pointer by one, and the pointer wraps from 255 to 0. The next byte is sent only after the master acknowledges.
- R6: A master no-acknowledge ends the read and releases SDA. A later read with no pointer write returns the byte after the last one sent.
- R7: A stop that ends a write in which a byte was stored starts a busy period of BUSY_CYCLES system clocks. During it, the slave address is not acknowledged and nothing is stored. After it ends, the address is acknowledged again.
- R8: A write sequence that stores no byte (pointer only) does not start a busy period.
- R9: A third and later data byte in the same write sequence is not acknowledged and is not stored.
- R10: The slave changes its SDA drive only after SCL falls or after a start or stop, never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap_i | input | 3 | Strap pins giving address bits 3:1 |
| sda_pull_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench targets the pointer wrap from 255 to 0. A design that kept a 9-bit pointer, or stopped at 255, would return an erased byte where 0x0B is expected. It also addresses the slave right after a storing write and again after the busy window ends. A timer that never started would acknowledge too early, and one that never cleared would lock the slave out. A third data byte in one write must be refused and must leave memory untouched, which catches a pointer that runs on into page writes. A pointer-only write must not raise the busy period. A bus monitor reports any change of the slave's drive while SCL is high, since such a change would look like a false start or stop to the master.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_WR_BYTE, ST_ACK_WR, ST_RD_BYTE, ST_RD_ACK
  } bus_state_t;

  // contents loaded at reset into the identification half
  function automatic logic [BYTE_W-1:0] factory_byte(input int unsigned idx);
    return BYTE_W'((idx * 37 + 11) & 255);
  endfunction
endpackage

// File: rtl/spd_sync.sv
`timescale 1ns/1ps
module spd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // bit 1 = SCL, bit 0 = SDA
  logic [1:0] stage_q [STAGES];
  logic [1:0] prev_q;
  logic [1:0] cur;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= 2'b11;
        else         stage_q[0] <= {scl_i, sda_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 2'b11;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign cur = stage_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= cur;
  end

  assign sda_lvl_o  = cur[0];
  assign scl_rise_o = cur[1] & ~prev_q[1];
  assign scl_fall_o = ~cur[1] & prev_q[1];
  assign start_o    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
  assign stop_o     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/spd_busy_timer.sv
`timescale 1ns/1ps
module spd_busy_timer #(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (kick_i)         cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_kick_sets_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> busy_o);
endmodule

// File: rtl/spd_store.sv
`timescale 1ns/1ps
module spd_store
  import spd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < HALF) ? factory_byte(i) : '1;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spd_bus_ctrl.sv
`timescale 1ns/1ps
module spd_bus_ctrl
  import spd_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              kick_o,
  output logic              sda_low_o
);
  bus_state_t        state_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] tx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rw_q;
  logic              have_ptr_q;
  logic              stored_q;
  logic              mack_q;
  logic              sda_low_q;
  logic              wr_en_q;
  logic [PTR_W-1:0]  wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic              kick_q;
  logic              addr_hit;

  assign addr_hit = (shift_q[7:1] == {DEV_TYPE, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      shift_q    <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      have_ptr_q <= 1'b0;
      stored_q   <= 1'b0;
      mack_q     <= 1'b0;
      sda_low_q  <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      kick_q     <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      kick_q  <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR;
        bit_q      <= '0;
        sda_low_q  <= 1'b0;
        have_ptr_q <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        sda_low_q <= 1'b0;
        if (stored_q) begin
          kick_q   <= 1'b1;
          stored_q <= 1'b0;
        end
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shift_q <= {shift_q[6:0], sda_lvl_i};
              bit_q   <= bit_q + 4'd1;
            end else if (scl_fall_i && bit_q == 4'd8) begin
              if (addr_hit && !busy_i) begin
                sda_low_q <= 1'b1;
                rw_q      <= shift_q[0];
                state_q   <= ST_ACK_ADDR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_rise_i) begin
              bit_q <= 4'd9;
            end else if (scl_fall_i && bit_q == 4'd9) begin
              bit_q <= '0;
              if (rw_q) begin
                tx_q      <= rd_data_i;
                ptr_q     <= ptr_q + 1'b1;
                sda_low_q <= ~rd_data_i[7];
                state_q   <= ST_RD_BYTE;
              end else begin
                sda_low_q <= 1'b0;
                state_q   <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise_i) begin
              shift_q <= {shift_q[6:0], sda_lvl_i};
              bit_q   <= bit_q + 4'd1;
            end else if (scl_fall_i && bit_q == 4'd8) begin
              if (!have_ptr_q) begin
                ptr_q      <= PTR_W'(shift_q);
                have_ptr_q <= 1'b1;
                sda_low_q  <= 1'b1;
                state_q    <= ST_ACK_WR;
              end else if (!stored_q) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= shift_q;
                ptr_q     <= ptr_q + 1'b1;
                stored_q  <= 1'b1;
                sda_low_q <= 1'b1;
                state_q   <= ST_ACK_WR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACK_WR: begin
            if (scl_rise_i) begin
              bit_q <= 4'd9;
            end else if (scl_fall_i && bit_q == 4'd9) begin
              bit_q     <= '0;
              sda_low_q <= 1'b0;
              state_q   <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_rise_i) begin
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_q == 4'd8) begin
                sda_low_q <= 1'b0;
                state_q   <= ST_RD_ACK;
              end else if (bit_q != 4'd0) begin
                sda_low_q <= ~tx_q[6];
                tx_q      <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_lvl_i;
              bit_q  <= 4'd9;
            end else if (scl_fall_i && bit_q == 4'd9) begin
              bit_q <= '0;
              if (mack_q) begin
                tx_q      <= rd_data_i;
                ptr_q     <= ptr_q + 1'b1;
                sda_low_q <= ~rd_data_i[7];
                state_q   <= ST_RD_BYTE;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign kick_o    = kick_q;
  assign sda_low_o = sda_low_q;

  assert_ack_only_when_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK_ADDR) |-> !busy_i);

  assert_no_store_while_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !busy_i);

  assert_idle_releases_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_low_o);

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> $past(scl_fall_i || start_i || stop_i));
endmodule

// File: rtl/spd_eeprom_slave.sv
`timescale 1ns/1ps
module spd_eeprom_slave
  import spd_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_low_o
);
  logic              sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic              busy, kick, wr_en;
  logic [PTR_W-1:0]  rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;

  spd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  spd_bus_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .strap_i    (strap_i),
    .busy_i     (busy),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .kick_o     (kick),
    .sda_low_o  (sda_pull_low_o)
  );

  spd_store #(.AW(PTR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  spd_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick),
    .busy_o (busy)
  );
endmodule

// File: tb/spd_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module spd_eeprom_slave_tb_top;
  localparam int BUSY = 3000;
  localparam int Q    = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV   = {4'b1010, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic dut_low;
  logic sda_bus;
  int   n_cmp = 0;
  int   n_err = 0;
  int   r10_viol = 0;
  logic prev_low = 1'b0;
  logic prev_scl = 1'b1;

  always #10 clk = ~clk;

  assign sda_bus = ~(m_low | dut_low);

  spd_eeprom_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .scl_i          (m_scl),
    .sda_i          (sda_bus),
    .strap_i        (STRAP),
    .sda_pull_low_o (dut_low)
  );

  // R10 monitor: slave drive must not move while SCL stays high
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && (dut_low !== prev_low)) r10_viol++;
    prev_low <= dut_low;
    prev_scl <= m_scl;
  end

  function automatic logic [7:0] exp_init(input int a);
    return (a < 128) ? 8'((a * 37 + 11) % 256) : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); m_low = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      d[i] = x;
    end
    bit_out(~give_ack);
  endtask

  task automatic write_at(input logic [7:0] a, input logic [7:0] d, input string req);
    logic k0, k1, k2;
    bus_start(); send({DEV, 1'b0}, k0); send(a, k1); send(d, k2); bus_stop();
    chk(req, {5'd0, k0, k1, k2}, 8'h07);
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d, input string req);
    logic k0, k1, k2;
    bus_start(); send({DEV, 1'b0}, k0); send(a, k1);
    bus_start(); send({DEV, 1'b1}, k2); recv(1'b0, d); bus_stop();
    chk(req, {5'd0, k0, k1, k2}, 8'h07);
  endtask

  task automatic wait_busy();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 sda released", {7'd0, sda_bus}, 8'h01);
    read_at(8'h00, d, "R4 ack"); chk("R1 loc 0", d, exp_init(0));
    read_at(8'h05, d, "R4 ack"); chk("R1 loc 5", d, exp_init(5));
    read_at(8'h7F, d, "R4 ack"); chk("R1 loc 127", d, exp_init(127));
    read_at(8'h80, d, "R4 ack"); chk("R1 loc 128", d, 8'hFF);
    read_at(8'hFF, d, "R4 ack"); chk("R1 loc 255", d, 8'hFF);
  endtask

  task automatic t_address();
    logic k;
    bus_start(); send({4'b1010, 3'b100, 1'b0}, k); bus_stop();
    chk("R2 wrong strap nack", {7'd0, k}, 8'h00);
    bus_start(); send({4'b1011, STRAP, 1'b0}, k); bus_stop();
    chk("R2 wrong type nack", {7'd0, k}, 8'h00);
    bus_start(); send({DEV, 1'b0}, k); bus_stop();
    chk("R2 match ack", {7'd0, k}, 8'h01);
  endtask

  task automatic t_write();
    logic [7:0] d;
    write_at(8'h10, 8'h3C, "R3 acks low half"); wait_busy();
    read_at(8'h10, d, "R4 ack"); chk("R3 low half stored", d, 8'h3C);
    write_at(8'hC0, 8'h5A, "R3 acks high half"); wait_busy();
    read_at(8'hC0, d, "R4 ack"); chk("R3 high half stored", d, 8'h5A);
  endtask

  task automatic t_busy();
    logic k;
    logic [7:0] d;
    write_at(8'h30, 8'h77, "R7 write acks");
    bus_start(); send({DEV, 1'b0}, k); bus_stop();
    chk("R7 nack while busy", {7'd0, k}, 8'h00);
    wait_busy();
    bus_start(); send({DEV, 1'b0}, k); bus_stop();
    chk("R7 ack after busy", {7'd0, k}, 8'h01);
    read_at(8'h30, d, "R4 ack"); chk("R7 data kept", d, 8'h77);
  endtask

  task automatic t_ptr_only();
    logic k0, k1, k;
    bus_start(); send({DEV, 1'b0}, k0); send(8'h44, k1); bus_stop();
    bus_start(); send({DEV, 1'b0}, k); bus_stop();
    chk("R8 no busy after pointer-only", {6'd0, k0 & k1, k}, 8'h03);
  endtask

  task automatic t_seq_and_nack();
    logic k0, k1, k2;
    logic [7:0] d;
    bus_start(); send({DEV, 1'b0}, k0); send(8'h40, k1);
    bus_start(); send({DEV, 1'b1}, k2);
    chk("R5 seq acks", {5'd0, k0, k1, k2}, 8'h07);
    for (int i = 0; i < 4; i++) begin
      recv(i != 3, d);
      chk("R5 sequential byte", d, exp_init(8'h40 + i));
    end
    bus_stop();
    bus_start(); send({DEV, 1'b0}, k0); send(8'hFE, k1);
    bus_start(); send({DEV, 1'b1}, k2);
    recv(1'b1, d); chk("R5 byte FE", d, 8'hFF);
    recv(1'b1, d); chk("R5 byte FF", d, 8'hFF);
    recv(1'b0, d); chk("R5 wrap to 0", d, exp_init(0));
    chk("R6 released after master nack", {7'd0, sda_bus}, 8'h01);
    bus_stop();
    bus_start(); send({DEV, 1'b1}, k2); recv(1'b0, d); bus_stop();
    chk("R6 current read continues", d, exp_init(1));
  endtask

  task automatic t_third_byte();
    logic k0, k1, k2, k3;
    logic [7:0] d;
    bus_start(); send({DEV, 1'b0}, k0); send(8'h20, k1); send(8'h11, k2); send(8'h22, k3);
    bus_stop();
    chk("R9 acks", {4'd0, k0, k1, k2, k3}, 8'h0E);
    wait_busy();
    read_at(8'h20, d, "R4 ack"); chk("R9 first data stored", d, 8'h11);
    read_at(8'h21, d, "R4 ack"); chk("R9 extra byte not stored", d, exp_init(8'h21));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_address();
    t_write();
    t_busy();
    t_ptr_only();
    t_seq_and_nack();
    t_third_byte();
    chk("R10 drive stable while SCL high", 8'(r10_viol), 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule